// File: doc/BRIEF.md
# Serial ADC Port Emulator

This block is a digital stand-in for the serial port of a two-input, 12-bit successive-approximation converter. It runs on a fast system clock and watches three device-side lines: convert, shift clock and serial data in. It drives a serial data output with a separate output-enable, which a pad or a bench resolves to high impedance. The analog front end is replaced by four parallel sample words: one for each single-ended channel and one for each of the two differential pairings. The sample word that the multiplexer setting selects is captured when convert rises.

The emulator reproduces the frame rules a host controller must respect. A busy window follows each conversion start. The model sleeps if convert stays high after that window. The output is enabled only while convert is low. The result goes out MSB first and is followed by an endless run of zeros. Only the first two serial-in bits of a frame are taken, and the multiplexer setting they carry takes effect at the next conversion, not the current one. Two kinds of host misbehaviour raise one-cycle error pulses.

All lines are sampled on the system clock. Edges on convert and shift clock are found by comparing each line with its value one clock earlier. Each output updates on the system clock edge that sees the causing input change.

Top module: `adc_port_emu`

## Requirements
- R1: While convert is high, `sdo_oe_o` is low and `sdo_o` is 0. `sdo_oe_o` rises on the clock edge that sees convert fall.
- R2: A rising convert edge captures the sample word chosen by the multiplexer setting. Changing the sample inputs afterwards does not alter the word shifted out in the next frame.
- R3: `busy_o` is high for exactly `CONV_CYCLES` clocks, starting at the clock edge that sees convert rise.
- R4: If convert is still high when the busy window ends, `sleep_o` goes high and `busy_o` goes low on the same edge. `sleep_o` is low during a frame, when convert is low.
- R5: The MSB of the captured word appears on `sdo_o` when convert falls. Each falling shift-clock edge then moves the output to the next lower bit.
- R6: After the LSB has been shifted out, every further falling shift-clock edge in the frame produces 0.
- R7: The first serial-in bit on a rising shift-clock edge after convert falls is the single-ended flag. The second is the odd/sign bit. Settings {1,0}, {1,1}, {0,0} and {0,1} select channel 0, channel 1, pair 0-minus-1 and pair 1-minus-0. The setting applies to the next conversion start, so the frame that carries it still shows the earlier selection.
- R8: Serial-in bits after the second in a frame have no effect on the multiplexer setting.
- R9: After reset the multiplexer setting is channel 0, single-ended.
- R10: If convert falls while `busy_o` is high, `err_early_o` pulses for one clock, the busy window ends, and the frame starts with the captured word.
- R11: A rising shift-clock edge while convert is high makes `err_sck_o` pulse for one clock.
- R12: A frame that ends with fewer than two serial-in bits leaves the multiplexer setting unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all lines are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| conv_i | input | 1 | Convert line from the host |
| sck_i | input | 1 | Shift clock from the host |
| sdi_i | input | 1 | Serial configuration data from the host |
| smp_ch0_i | input | DATA_W | Sample word for channel 0 single-ended |
| smp_ch1_i | input | DATA_W | Sample word for channel 1 single-ended |
| smp_p01_i | input | DATA_W | Sample word for the pair channel 0 minus channel 1 |
| smp_p10_i | input | DATA_W | Sample word for the pair channel 1 minus channel 0 |
| sdo_o | output | 1 | Serial result data, 0 while disabled |
| sdo_oe_o | output | 1 | Output enable; low means high impedance |
| busy_o | output | 1 | Conversion window in progress |
| sleep_o | output | 1 | Idle with convert held high after conversion |
| err_early_o | output | 1 | One-clock pulse: convert fell during busy window |
| err_sck_o | output | 1 | One-clock pulse: shift clock rose with convert high |

## Verification
The hardest behaviour to observe is the one-frame latency of the multiplexer setting. The setting itself is never visible. Its effect shows only in the word shifted out one frame after the frame that carried it. The bench therefore chains frames. Each frame sends a new setting while checking that its own word still matches the previous setting. Distinct sample values make each selection recognisable. One frame sends only a single configuration bit. The frame after it must then still show the earlier selection.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

  // Multiplexer setting, first serial bit in the MSB.
  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;

  localparam mux_cfg_t MUX_CFG_RST = '{single: 1'b1, odd: 1'b0};
  localparam int       CFG_BITS    = $bits(mux_cfg_t);

  typedef enum logic [1:0] {
    SRC_CH0 = 2'd0,
    SRC_CH1 = 2'd1,
    SRC_P01 = 2'd2,
    SRC_P10 = 2'd3
  } src_t;

  function automatic src_t cfg_to_src(input mux_cfg_t c);
    src_t s;
    case ({c.single, c.odd})
      2'b10:   s = SRC_CH0;
      2'b11:   s = SRC_CH1;
      2'b00:   s = SRC_P01;
      default: s = SRC_P10;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/adc_emu_edge.sv
module adc_emu_edge #(
  parameter int           N       = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);

  for (genvar i = 0; i < N; i++) begin : g_line
    logic prev_q;

    always_ff @(posedge clk) begin
      if (rst) prev_q <= RST_VAL[i];
      else     prev_q <= din[i];
    end

    assign rise[i] = din[i] & ~prev_q;
    assign fall[i] = ~din[i] & prev_q;
  end

endmodule

// File: rtl/adc_emu_timer.sv
module adc_emu_timer #(
  parameter int CONV_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic conv_lvl,
  input  logic start,
  input  logic abort,
  output logic busy,
  output logic sleep
);

  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sleep_q;

  always_comb begin
    if (start)             cnt_d = CW'(CONV_CYCLES);
    else if (abort)        cnt_d = '0;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    else                   cnt_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      sleep_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      sleep_q <= conv_lvl && (cnt_d == '0);
    end
  end

  assign busy  = (cnt_q != '0);
  assign sleep = sleep_q;

endmodule

// File: rtl/adc_emu_frame.sv
module adc_emu_frame
  import adc_emu_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   conv_lvl,
  input  logic                   conv_rise,
  input  logic                   conv_fall,
  input  logic                   sck_rise,
  input  logic                   sck_fall,
  input  logic                   sdi,
  input  logic [3:0][DATA_W-1:0] smp_bus,
  output logic                   sdo,
  output logic                   sdo_oe
);

  localparam int CNT_W = $clog2(CFG_BITS + 1);

  mux_cfg_t             cfg_q;
  logic [CFG_BITS-1:0]  cfg_sh_q;
  logic                 commit_q;
  logic [CNT_W-1:0]     sdi_cnt_q;
  logic [DATA_W-1:0]    hold_q;
  logic [DATA_W-1:0]    shreg_q;
  logic                 oe_q;
  mux_cfg_t             cfg_eff;
  src_t                 src_sel;

  // A setting completed on the previous clock is already in force.
  assign cfg_eff = commit_q ? mux_cfg_t'(cfg_sh_q) : cfg_q;
  assign src_sel = cfg_to_src(cfg_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= MUX_CFG_RST;
      cfg_sh_q  <= '0;
      commit_q  <= 1'b0;
      sdi_cnt_q <= '0;
      hold_q    <= '0;
      shreg_q   <= '0;
      oe_q      <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (commit_q) cfg_q <= mux_cfg_t'(cfg_sh_q);

      if (conv_rise) begin
        hold_q <= smp_bus[src_sel];
        oe_q   <= 1'b0;
      end else if (conv_fall) begin
        oe_q      <= 1'b1;
        shreg_q   <= hold_q;
        sdi_cnt_q <= '0;
      end else if (oe_q && !conv_lvl) begin
        if (sck_fall) shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
        if (sck_rise && (sdi_cnt_q < CNT_W'(CFG_BITS))) begin
          cfg_sh_q  <= {cfg_sh_q[CFG_BITS-2:0], sdi};
          sdi_cnt_q <= sdi_cnt_q + 1'b1;
          commit_q  <= (sdi_cnt_q == CNT_W'(CFG_BITS - 1));
        end
      end
    end
  end

  assign sdo    = oe_q & shreg_q[DATA_W-1];
  assign sdo_oe = oe_q;

endmodule

// File: rtl/adc_port_emu.sv
module adc_port_emu
  import adc_emu_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CONV_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_i,
  input  logic              sck_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] smp_ch0_i,
  input  logic [DATA_W-1:0] smp_ch1_i,
  input  logic [DATA_W-1:0] smp_p01_i,
  input  logic [DATA_W-1:0] smp_p10_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              sleep_o,
  output logic              err_early_o,
  output logic              err_sck_o
);

  localparam int LINE_CONV = 0;
  localparam int LINE_SCK  = 1;

  logic [1:0]              line_rise, line_fall;
  logic [3:0][DATA_W-1:0]  smp_bus;
  logic                    busy;
  logic                    err_early_q, err_sck_q;

  assign smp_bus[SRC_CH0] = smp_ch0_i;
  assign smp_bus[SRC_CH1] = smp_ch1_i;
  assign smp_bus[SRC_P01] = smp_p01_i;
  assign smp_bus[SRC_P10] = smp_p10_i;

  // Convert idles high, shift clock idles low.
  adc_emu_edge #(.N(2), .RST_VAL(2'b01)) i_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({sck_i, conv_i}),
    .rise (line_rise),
    .fall (line_fall)
  );

  adc_emu_timer #(.CONV_CYCLES(CONV_CYCLES)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .conv_lvl (conv_i),
    .start    (line_rise[LINE_CONV]),
    .abort    (line_fall[LINE_CONV]),
    .busy     (busy),
    .sleep    (sleep_o)
  );

  adc_emu_frame #(.DATA_W(DATA_W)) i_frame (
    .clk       (clk),
    .rst       (rst),
    .conv_lvl  (conv_i),
    .conv_rise (line_rise[LINE_CONV]),
    .conv_fall (line_fall[LINE_CONV]),
    .sck_rise  (line_rise[LINE_SCK]),
    .sck_fall  (line_fall[LINE_SCK]),
    .sdi       (sdi_i),
    .smp_bus   (smp_bus),
    .sdo       (sdo_o),
    .sdo_oe    (sdo_oe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_early_q <= 1'b0;
      err_sck_q   <= 1'b0;
    end else begin
      err_early_q <= line_fall[LINE_CONV] & busy;
      err_sck_q   <= line_rise[LINE_SCK] & conv_i;
    end
  end

  assign busy_o      = busy;
  assign err_early_o = err_early_q;
  assign err_sck_o   = err_sck_q;

endmodule

// File: rtl/adc_port_emu_chk.sv
module adc_port_emu_chk (
  input logic clk,
  input logic rst,
  input logic conv_i,
  input logic sck_i,
  input logic sdo_o,
  input logic sdo_oe_o,
  input logic busy_o,
  input logic sleep_o,
  input logic err_early_o,
  input logic err_sck_o
);

  // R1
  oe_off_conv_high_chk: assert property (@(posedge clk) disable iff (rst)
    conv_i |=> !sdo_oe_o);

  // R1
  sdo_quiet_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe_o |-> !sdo_o);

  // R3
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_i) |=> busy_o);

  // R4
  busy_sleep_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && sleep_o));

  // R10
  early_fall_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(conv_i) && busy_o) |=> (err_early_o && !busy_o && sdo_oe_o));

  // R11
  sck_conv_high_flag_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sck_i) && conv_i) |=> err_sck_o);

endmodule

bind adc_port_emu adc_port_emu_chk i_chk (
  .clk         (clk),
  .rst         (rst),
  .conv_i      (conv_i),
  .sck_i       (sck_i),
  .sdo_o       (sdo_o),
  .sdo_oe_o    (sdo_oe_o),
  .busy_o      (busy_o),
  .sleep_o     (sleep_o),
  .err_early_o (err_early_o),
  .err_sck_o   (err_sck_o)
);

// File: tb/test_adc_port_emu.sv
module test_adc_port_emu;

  localparam int DATA_W = 12;
  localparam int CONV_CYCLES = 16;

  localparam logic [DATA_W-1:0] V_CH0 = 12'hA5C;
  localparam logic [DATA_W-1:0] V_CH1 = 12'h3E1;
  localparam logic [DATA_W-1:0] V_P01 = 12'hF0F;
  localparam logic [DATA_W-1:0] V_P10 = 12'h8C3;

  logic clk = 1'b0;
  logic rst, conv, sck, sdi;
  logic [DATA_W-1:0] s_ch0, s_ch1, s_p01, s_p10;
  logic sdo, sdo_oe, busy, sleep, err_early, err_sck;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  adc_port_emu #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) i_adc_port_emu (
    .clk         (clk),
    .rst         (rst),
    .conv_i      (conv),
    .sck_i       (sck),
    .sdi_i       (sdi),
    .smp_ch0_i   (s_ch0),
    .smp_ch1_i   (s_ch1),
    .smp_p01_i   (s_p01),
    .smp_p10_i   (s_p10),
    .sdo_o       (sdo),
    .sdo_oe_o    (sdo_oe),
    .busy_o      (busy),
    .sleep_o     (sleep),
    .err_early_o (err_early),
    .err_sck_o   (err_sck)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Raise convert and let the busy window run out.
  task automatic finish_frame();
    conv = 1'b1;
    nclk(CONV_CYCLES + 2);
  endtask

  task automatic t_reset();
    rst = 1'b1; conv = 1'b1; sck = 1'b0; sdi = 1'b0;
    nclk(4);
    rst = 1'b0;
    nclk(1);
    chk("R1", "oe after reset", sdo_oe, 0);
    chk("R1", "sdo after reset", sdo, 0);
    chk("R3", "busy after reset", busy, 0);
    chk("R10", "err_early after reset", err_early, 0);
    chk("R11", "err_sck after reset", err_sck, 0);
    chk("R4", "sleep idle high", sleep, 1);
  endtask

  // Short frame without shift clocks, then count the busy window.
  task automatic t_busy_window();
    int busy_cnt = 0;
    int oe_seen = 0;
    conv = 1'b0;
    nclk(2);
    conv = 1'b1;
    for (int i = 0; i < CONV_CYCLES; i++) begin
      @(negedge clk);
      if (busy) busy_cnt++;
      if (sdo_oe || sdo) oe_seen++;
    end
    chk("R3", "busy cycles", busy_cnt, CONV_CYCLES);
    chk("R1", "output active during convert high", oe_seen, 0);
    @(negedge clk);
    chk("R3", "busy ended", busy, 0);
    chk("R4", "sleep after window", sleep, 1);
    nclk(2);
  endtask

  task automatic run_frame(input string req, input logic [11:0] sdi_pat,
                           input int extra, input logic [DATA_W-1:0] exp);
    logic [DATA_W-1:0] word;
    int nonzero = 0;
    conv = 1'b0;
    @(negedge clk);
    chk("R1", "oe after convert fall", sdo_oe, 1);
    chk("R4", "sleep during frame", sleep, 0);
    word[DATA_W-1] = sdo;
    for (int r = 0; r < DATA_W - 1 + extra; r++) begin
      sck = 1'b1;
      sdi = (r < 12) ? sdi_pat[11 - r] : 1'b0;
      @(negedge clk);
      sck = 1'b0;
      @(negedge clk);
      if (r < DATA_W - 1) word[DATA_W - 2 - r] = sdo;
      else if (sdo) nonzero++;
    end
    sdi = 1'b0;
    chk(req, "frame word", int'(word), int'(exp));
    if (extra > 0) chk("R6", "trailing bits nonzero", nonzero, 0);
    finish_frame();
  endtask

  // Frame with a single configuration bit.
  task automatic t_partial_cfg();
    conv = 1'b0;
    nclk(1);
    sck = 1'b1; sdi = 1'b0;
    nclk(1);
    sck = 1'b0;
    nclk(1);
    finish_frame();
    // Setting must still be channel 0 (R12); this frame sends {1,1}.
    run_frame("R12", 12'b1100_0000_0000, 0, V_CH0);
  endtask

  task automatic t_early_fall();
    conv = 1'b0;
    nclk(2);
    conv = 1'b1;            // converts channel 1 (set by the last frame)
    nclk(3);
    chk("R10", "busy before early fall", busy, 1);
    conv = 1'b0;
    @(negedge clk);
    chk("R10", "err_early pulse", err_early, 1);
    chk("R10", "busy aborted", busy, 0);
    chk("R10", "oe after early fall", sdo_oe, 1);
    chk("R10", "MSB after early fall", sdo, int'(V_CH1[DATA_W-1]));
    @(negedge clk);
    chk("R10", "err_early one clock", err_early, 0);
    finish_frame();
  endtask

  task automatic t_sck_conv_high();
    sck = 1'b1;
    @(negedge clk);
    chk("R11", "err_sck pulse", err_sck, 1);
    sck = 1'b0;
    @(negedge clk);
    chk("R11", "err_sck one clock", err_sck, 0);
    chk("R1", "oe stays low", sdo_oe, 0);
  endtask

  initial begin
    s_ch0 = V_CH0; s_ch1 = V_CH1; s_p01 = V_P01; s_p10 = V_P10;
    t_reset();
    t_busy_window();                                  // converts channel 0 (R9)
    run_frame("R9 R5", 12'b1100_0000_0000, 0, V_CH0); // sends channel 1
    s_ch1 = 12'h000;                                  // after capture (R2)
    run_frame("R2 R7", 12'b0011_1111_1111, 0, V_CH1); // sends pair 0-1
    s_ch1 = V_CH1;
    run_frame("R8 R7", 12'b0100_0000_0000, 0, V_P01); // sends pair 1-0
    run_frame("R7 R5", 12'b1000_0000_0000, 6, V_P10); // sends channel 0
    t_partial_cfg();
    t_early_fall();
    t_sck_conv_high();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule